// File: doc/BRIEF.md
# Control-Word Separator for a 64-bit Program Stream

This block sits between a program fetch path and an instruction decoder. It accepts a program as a stream of 64-bit words over a valid/ready handshake. It strips the scheduling control words out of that stream and forwards them on a dedicated output. The executable instructions go to a second output.

A start pulse opens each program and latches a mode. In header mode the program begins with a 0x50-byte (ten-word) descriptor, and the block drops it. In headerless mode code begins at the very first word. From the first code word on, the stream is treated as groups of four words (32 bytes each):

- Word zero of each group is the scheduling word. It leaves on the control output, tagged with its group index.
- The other three words are instructions. Each leaves on the instruction output with its byte address relative to the code start.
- An all-zero instruction is flagged as a no-op.

An end-of-program marker that lands anywhere other than on the last word of a group raises a sticky misalignment flag.

Top module: `ctrl_word_splitter`

## Requirements
- R1: After reset, both output valids and the misalignment flag are 0, and the block is in headerless mode with its counters at zero. A word sent without a start pulse is therefore treated as the scheduling word of group 0.
- R2: In header mode (`hdr_mode_i`=1 at start), the first ten accepted words appear on neither output. While these header words are pending, `in_ready_o` is 1 regardless of the output readies.
- R3: In headerless mode (`hdr_mode_i`=0 at start), the first accepted word is already the scheduling word of group 0.
- R4: The code word at position 0 of each four-word group is presented only on the control output. `ctl_group_o` equals the group index, counted from 0 at the code start.
- R5: Code words at positions 1 to 3 are presented only on the instruction output. `ins_addr_o` equals group*32 + position*8, modulo 2^AW.
- R6: `ins_nop_o` is 1 exactly when the presented instruction word is all zeros.
- R7: Once the header is done, `in_ready_o` equals the ready of the output that the current word is destined for. No word is dropped or repeated while that output stalls.
- R8: A start pulse clears the group, position and header counters, latches `hdr_mode_i` and clears the misalignment flag. No input word is accepted in the start cycle.
- R9: `misalign_o` is set when a word carrying `in_last_i` is accepted at a position other than 3 or inside the header. It is not set when that word sits at position 3. Once set, it holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Program start pulse |
| hdr_mode_i | input | 1 | 1: program carries a ten-word header; sampled on start |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 64 | Input word |
| in_last_i | input | 1 | Marks the final word of the program |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| ctl_valid_o | output | 1 | Scheduling word valid |
| ctl_data_o | output | 64 | Scheduling word |
| ctl_group_o | output | GW (8) | Group index of the scheduling word |
| ctl_ready_i | input | 1 | Control output ready |
| ins_valid_o | output | 1 | Instruction valid |
| ins_data_o | output | 64 | Instruction word |
| ins_addr_o | output | GW+5 (13) | Byte address from code start |
| ins_nop_o | output | 1 | Instruction is all zeros |
| ins_ready_i | input | 1 | Instruction output ready |
| misalign_o | output | 1 | Sticky: program ended mid-group |

## Verification
The bench targets the boundary between the tenth header word and the first scheduling word. A design with an off-by-one header count would either leak a header word or swallow group 0's control word.

It randomly stalls whichever output is not the destination. A design that gates `in_ready_o` with the wrong ready would either lose words or stall without cause.

It ends programs at each position within a group and inside the header, to catch a flag that tests the wrong position. It also holds the input valid during the start cycle, to catch a design that consumes a word while its counters are being cleared.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  localparam int unsigned WORD_W      = 64;
  localparam int unsigned HDR_WORDS   = 10;  // 0x50 bytes
  localparam int unsigned GROUP_WORDS = 4;   // 0x20 bytes
  localparam int unsigned SLOT_W      = $clog2(GROUP_WORDS);
  localparam int unsigned BYTE_SH     = $clog2(WORD_W / 8);

  typedef enum logic [1:0] {
    ROUTE_DROP = 2'd0,
    ROUTE_CTL  = 2'd1,
    ROUTE_INS  = 2'd2
  } route_e;
endpackage

// File: rtl/csplit_hdr_skip.sv
module csplit_hdr_skip #(
  parameter int unsigned HDR_WORDS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic take_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HDR_WORDS + 1);
  localparam logic [CW-1:0] HDR_N = CW'(HDR_WORDS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= mode_i ? HDR_N : '0;
    else if (take_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_hdr_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && cnt_q == CW'(1)) |=> !active_o);
  assert_hdr_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_o == $past(mode_i)));
endmodule

// File: rtl/csplit_group_tracker.sv
module csplit_group_tracker #(
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned GW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              take_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [GW-1:0]     group_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o  <= '0;
      group_o <= '0;
    end else if (start_i) begin
      slot_o  <= '0;
      group_o <= '0;
    end else if (take_i) begin
      slot_o <= slot_o + 1'b1;
      if (slot_o == SLOT_LAST) group_o <= group_o + 1'b1;
    end
  end

  assert_group_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && slot_o == SLOT_LAST) |=>
      (slot_o == '0 && group_o == $past(group_o) + 1'b1));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !start_i) |=> ($stable(slot_o) && $stable(group_o)));
endmodule

// File: rtl/csplit_router.sv
module csplit_router
  import csplit_pkg::*;
#(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic              hdr_active_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              ctl_ready_i,
  input  logic              ins_ready_i,
  output logic              ctl_valid_o,
  output logic              ins_valid_o,
  output logic              in_ready_o
);
  route_e route;

  always_comb begin
    if (hdr_active_i)        route = ROUTE_DROP;
    else if (slot_i == '0)   route = ROUTE_CTL;
    else                     route = ROUTE_INS;
  end

  always_comb begin
    ctl_valid_o = 1'b0;
    ins_valid_o = 1'b0;
    in_ready_o  = 1'b0;
    if (!start_i) begin
      unique case (route)
        ROUTE_DROP: in_ready_o = 1'b1;
        ROUTE_CTL: begin
          ctl_valid_o = in_valid_i;
          in_ready_o  = ctl_ready_i;
        end
        ROUTE_INS: begin
          ins_valid_o = in_valid_i;
          in_ready_o  = ins_ready_i;
        end
        default: in_ready_o = 1'b0;
      endcase
    end
  end

  assert_one_dest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_valid_o, ins_valid_o}));
  assert_hdr_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_active_i |-> (!ctl_valid_o && !ins_valid_o));
  assert_start_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !in_ready_o);
  assert_ctl_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_valid_o && !ctl_ready_i) |-> !in_ready_o);
  assert_ins_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_o && !ins_ready_i) |-> !in_ready_o);
endmodule

// File: rtl/ctrl_word_splitter.sv
module ctrl_word_splitter
  import csplit_pkg::*;
#(
  parameter int unsigned GW = 8,
  parameter int unsigned AW = GW + SLOT_W + BYTE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hdr_mode_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              ctl_valid_o,
  output logic [WORD_W-1:0] ctl_data_o,
  output logic [GW-1:0]     ctl_group_o,
  input  logic              ctl_ready_i,
  output logic              ins_valid_o,
  output logic [WORD_W-1:0] ins_data_o,
  output logic [AW-1:0]     ins_addr_o,
  output logic              ins_nop_o,
  input  logic              ins_ready_i,
  output logic              misalign_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(GROUP_WORDS - 1);

  logic              take;
  logic              hdr_active;
  logic [SLOT_W-1:0] slot;
  logic [GW-1:0]     group;

  assign take = in_valid_i && in_ready_o;

  csplit_hdr_skip #(.HDR_WORDS(HDR_WORDS)) u_hdr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (hdr_mode_i),
    .take_i   (take),
    .active_o (hdr_active)
  );

  csplit_group_tracker #(.SLOT_W(SLOT_W), .GW(GW)) u_grp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .take_i  (take && !hdr_active),
    .slot_o  (slot),
    .group_o (group)
  );

  csplit_router #(.SLOT_W(SLOT_W)) u_rt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .in_valid_i   (in_valid_i),
    .hdr_active_i (hdr_active),
    .slot_i       (slot),
    .ctl_ready_i  (ctl_ready_i),
    .ins_ready_i  (ins_ready_i),
    .ctl_valid_o  (ctl_valid_o),
    .ins_valid_o  (ins_valid_o),
    .in_ready_o   (in_ready_o)
  );

  assign ctl_data_o  = in_data_i;
  assign ctl_group_o = group;
  assign ins_data_o  = in_data_i;
  assign ins_addr_o  = AW'({group, slot, {BYTE_SH{1'b0}}});
  assign ins_nop_o   = ins_valid_o && (in_data_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        misalign_o <= 1'b0;
    else if (start_i)   misalign_o <= 1'b0;
    else if (take && in_last_i && (hdr_active || slot != SLOT_LAST))
      misalign_o <= 1'b1;
  end

  assert_ins_offgrid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_o |-> (ins_addr_o[SLOT_W+BYTE_SH-1:BYTE_SH] != '0));
  assert_nop_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_nop_o |-> ins_valid_o);
  assert_flag_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(misalign_o) |-> $past(take && in_last_i));
  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !misalign_o);
endmodule

// File: tb/sim_ctrl_word_splitter.sv
module sim_ctrl_word_splitter;
  localparam int GW = 8;
  localparam int AW = GW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, hdr_mode = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [63:0] in_data = '0;
  logic ctl_ready = 1'b1, ins_ready = 1'b1;
  logic in_ready, ctl_valid, ins_valid, ins_nop, misalign;
  logic [63:0] ctl_data, ins_data;
  logic [GW-1:0] ctl_group;
  logic [AW-1:0] ins_addr;

  int checks = 0, fails = 0;
  int hdr_left = 0, idx = 0;
  bit exp_mis = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctrl_word_splitter #(.GW(GW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hdr_mode_i(hdr_mode),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
    .in_ready_o(in_ready), .ctl_valid_o(ctl_valid), .ctl_data_o(ctl_data),
    .ctl_group_o(ctl_group), .ctl_ready_i(ctl_ready), .ins_valid_o(ins_valid),
    .ins_data_o(ins_data), .ins_addr_o(ins_addr), .ins_nop_o(ins_nop),
    .ins_ready_i(ins_ready), .misalign_o(misalign)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int i);
    return AW'(i * 8);
  endfunction

  task automatic send_word(input logic [63:0] d, input bit last);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = last;
      ctl_ready = ($urandom % 4) != 0;
      ins_ready = ($urandom % 4) != 0;
      #1;
      if (hdr_left > 0) begin
        chk(in_ready == 1'b1, "R2 hdr ready", 64'(in_ready), 64'd1);
        chk(!ctl_valid && !ins_valid, "R2 hdr hidden", {ctl_valid, ins_valid}, 0);
        acc = 1;
      end else if (idx % 4 == 0) begin
        chk(in_ready == ctl_ready, "R7 ctl ready", 64'(in_ready), 64'(ctl_ready));
        chk(ctl_valid && !ins_valid && ctl_data == d, "R4 ctl word", ctl_data, d);
        chk(ctl_group == GW'(idx / 4), "R4 group", 64'(ctl_group), 64'(idx / 4));
        acc = ctl_ready;
      end else begin
        chk(in_ready == ins_ready, "R7 ins ready", 64'(in_ready), 64'(ins_ready));
        chk(ins_valid && !ctl_valid && ins_data == d, "R5 ins word", ins_data, d);
        chk(ins_addr == exp_addr(idx), "R5 addr", 64'(ins_addr), 64'(exp_addr(idx)));
        chk(ins_nop == (d == 0), "R6 nop", 64'(ins_nop), 64'(d == 0));
        acc = ins_ready;
      end
      @(posedge clk);
      if (acc) begin
        if (last && (hdr_left > 0 || idx % 4 != 3)) exp_mis = 1;
        if (hdr_left > 0) hdr_left--; else idx++;
      end
    end
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk(misalign == exp_mis, req, 64'(misalign), 64'(exp_mis));
  endtask

  task automatic do_start(input bit m);
    @(negedge clk);
    start = 1'b1; hdr_mode = m; in_valid = 1'b1; in_data = 64'hdead;
    ctl_ready = 1'b1; ins_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R8 start blocks", 64'(in_ready), 0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    hdr_left = m ? 10 : 0; idx = 0; exp_mis = 0;
    #1;
    chk(misalign == 1'b0, "R8 flag cleared", 64'(misalign), 0);
  endtask

  task automatic run_prog(input bit m, input int hdr_n, input int code_n);
    do_start(m);
    for (int i = 0; i < hdr_n + code_n; i++) begin
      logic [63:0] d;
      d = (($urandom % 4) == 0) ? 64'd0 : {$urandom, $urandom};
      send_word(d, i == hdr_n + code_n - 1);
    end
    idle_chk(m ? "R9 flag hdr prog" : "R9 flag R3 prog");
  endtask

  initial begin
    void'($urandom(32'd4242));
    #45 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!ctl_valid && !ins_valid && !misalign, "R1 reset outputs",
        {ctl_valid, ins_valid, misalign}, 0);
    // R1: no start -> headerless, group 0
    send_word(64'h1111, 1'b0);
    send_word(64'h0, 1'b0);
    idle_chk("R1 flag");
    // R2 boundary, R9 ends on position 3
    run_prog(1'b1, 10, 8);
    // R3 headerless, ends on position 1
    run_prog(1'b0, 0, 6);
    // R9 end inside header
    run_prog(1'b1, 5, 0);
    // R9 flag sticky until start
    send_word(64'h5, 1'b0);
    idle_chk("R9 sticky");
    for (int p = 0; p < 12; p++) begin
      bit m;
      int n;
      m = $urandom % 2;
      n = 1 + $urandom % 24;
      run_prog(m, m ? 10 : 0, n);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule